// File: doc/BRIEF.md
# Serial Configuration Register Slave with Persistent Shadow Copy

This block is a serial slave that holds the configuration words of a clock-generation datapath. The host frames each 32-bit command with a latch-enable line held low. The frame starts with a 4-bit command nibble and ends with a 28-bit payload, both sent least significant bit first. Nibble values 0 to 8 select a writable configuration word. One further code requests a read-back. Another code, paired with one of two exact payloads, copies the first eight words into a persistent shadow array. One of those payloads then seals the shadow array for good.

The serial lines are oversampled by the system clock. A frame is acted on only when latch-enable rises after exactly 32 sampled bits. Read data is shifted out during the frame that follows the request. The shadow array is modelled by internal registers. A power-on reset clears it. A soft reset reloads the working words from it and leaves the seal in place. All nine working words are presented in parallel to the rest of the chip.

Top module: `cfg_spi_slave`

## Requirements
- R1: Power-on reset (`por_n` low) clears all nine working words, the shadow array and the seal. A soft reset (`rst_n` low) reloads words 0..7 from the shadow array, clears word 8, and keeps the seal unchanged.
- R2: While `le` is low, a bit is taken from `mosi` on each rising `sclk` edge. The first bit received is nibble bit 0, bits 0..3 form the command nibble, and bits 4..31 form payload bits 0..27.
- R3: A complete frame with nibble 0..8 writes the 28-bit payload into the working word of that number, visible on `cfg_o[k*28 +: 28]`.
- R4: A complete frame with nibble 14, payload bits 27:4 zero and payload bits 3:0 equal to k (0..8) arms a read. During the next frame, `miso` presents the 32-bit word {word k, k} LSB first, with one bit valid before each rising `sclk`. Otherwise `miso` is 0.
- R5: A complete frame with nibble 15 and payload 0x0000001 copies words 0..7 into the shadow array and leaves the seal clear.
- R6: A complete frame with nibble 15 and payload 0x0000A03 (payload bits 11, 9, 1 and 0 set) copies words 0..7 into the shadow array and then sets the seal (`nvm_locked_o` = 1).
- R7: Once the seal is set, both copy commands leave the shadow array untouched, while writes to the working words still take effect.
- R8: Frames with nibble 9..13, with nibble 15 and any other payload, or with nibble 14 and a non-zero payload field 27:4 or a word number above 8, change no word, no shadow entry and no seal, and arm no read.
- R9: A frame of any bit count other than 32 is discarded without any effect.
- R10: Word 8 has no shadow entry, so after any copy and a soft reset it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| por_n | input | 1 | Synchronous power-on reset, active low; clears the shadow array and seal |
| rst_n | input | 1 | Synchronous soft reset, active low; reloads working words from the shadow array |
| sclk | input | 1 | Serial clock from the host |
| le | input | 1 | Frame enable; low during a frame, rising edge ends it |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read-back data to the host |
| cfg_o | output | 252 | Nine 28-bit working words, word k at bits k*28+27 .. k*28 |
| nvm_locked_o | output | 1 | Seal flag of the shadow array |

## Verification
A vector table drives writes with distinct patterns to the lowest, highest and middle word numbers, mixing all-ones, alternating and sparse payloads. Each write is read back both on `miso` and on `cfg_o`, so swapped word indices and bit-order faults show up as wrong values. Directed frames then separate the two copy payloads from near misses: 0x0000002, 0x0000003 and 0x0000A02 must do nothing. Short and long frames must be ignored, and malformed reads must return zeros. The persistence behaviour is observed only through soft resets. Each reset shows whether a copy took place, whether word 8 was excluded, and whether the seal blocked later copies while writes kept working.

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
  parameter int DW = 28,
  parameter int AW = 4,
  parameter int NREG = 9,
  parameter int NNVM = 8,
  parameter logic [AW-1:0] RD_CODE = 4'hE,
  parameter logic [AW-1:0] CP_CODE = 4'hF,
  parameter logic [DW-1:0] CP_OPEN = 28'h0000001,
  parameter logic [DW-1:0] CP_SEAL = 28'h0000A03
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              le,
  input  logic              mosi,
  output logic              miso,
  output logic [NREG*DW-1:0] cfg_o,
  output logic              nvm_locked_o
);
  localparam int FW = DW + AW;
  localparam int CW = $clog2(FW + 2);
  localparam logic [AW-1:0] LAST_REG = AW'(NREG - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FW);
  localparam logic [CW-1:0] OVER_CNT = CW'(FW + 1);

  logic [2:0] sclk_p, le_p;
  logic [1:0] mosi_p;
  logic [FW-1:0] rx, tx;
  logic [CW-1:0] cnt;
  logic [NREG-1:0][DW-1:0] ram;
  logic [NNVM-1:0][DW-1:0] nvm;
  logic [DW-1:0] reload [NREG];
  logic lock;

  wire any_rst = !por_n || !rst_n;
  wire sclk_rise = sclk_p[1] && !sclk_p[2];
  wire le_rise = le_p[1] && !le_p[2];
  wire in_frame = !le_p[1];

  wire [AW-1:0] f_addr = rx[AW-1:0];
  wire [DW-1:0] f_data = rx[FW-1:AW];
  wire full = (cnt == FULL_CNT);
  wire wr_hit = full && (f_addr <= LAST_REG);
  wire rd_ok = full && (f_addr == RD_CODE) && (f_data[DW-1:AW] == '0) &&
               (f_data[AW-1:0] <= LAST_REG);
  wire cp_hit = full && (f_addr == CP_CODE) && !lock &&
                ((f_data == CP_OPEN) || (f_data == CP_SEAL));

  always_ff @(posedge clk) begin
    if (any_rst) begin
      sclk_p <= '0;
      le_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      le_p   <= {le_p[1:0], le};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rx  <= '0;
      tx  <= '0;
      cnt <= '0;
    end else if (le_rise) begin
      cnt <= '0;
      tx  <= rd_ok ? {ram[f_data[AW-1:0]], f_data[AW-1:0]} : '0;
    end else if (in_frame && sclk_rise) begin
      rx <= {mosi_p[1], rx[FW-1:1]};
      tx <= tx >> 1;
      if (cnt != OVER_CNT) cnt <= cnt + CW'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reload
    if (g < NNVM) begin : g_backed
      assign reload[g] = nvm[g];
    end else begin : g_volatile
      assign reload[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      ram <= '0;
    end else if (!rst_n) begin
      for (int k = 0; k < NREG; k++) ram[k] <= reload[k];
    end else if (le_rise && wr_hit) begin
      for (int k = 0; k < NREG; k++)
        if (f_addr == AW'(k)) ram[k] <= f_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      nvm  <= '0;
      lock <= 1'b0;
    end else if (le_rise && cp_hit) begin
      for (int k = 0; k < NNVM; k++) nvm[k] <= ram[k];
      if (f_data == CP_SEAL) lock <= 1'b1;
    end
  end

  assign miso = in_frame && tx[0];
  assign cfg_o = ram;
  assign nvm_locked_o = lock;

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    lock |=> lock);
  p_nvm_frozen_r7: assert property (@(posedge clk) disable iff (!por_n)
    lock |=> $stable(nvm));
  p_nvm_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
    !le_rise |=> $stable(nvm));
  p_ram_quiet_r3: assert property (@(posedge clk) disable iff (any_rst)
    !le_rise |=> $stable(ram));
  p_short_frame_r9: assert property (@(posedge clk) disable iff (any_rst)
    (le_rise && cnt != FULL_CNT) |=> (tx == '0 && $stable(ram) && $stable(nvm)));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (any_rst)
    cnt <= OVER_CNT);
  p_seal_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(lock) |-> ($past(f_addr) == CP_CODE && $past(f_data) == CP_SEAL));
endmodule

// File: tb/test_cfg_spi_slave.sv
module test_cfg_spi_slave;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // row = {frame[31:0], read word number[3:0], expected word[27:0]}
  localparam logic [63:0] VEC [NV] = '{
    {28'h1234567, 4'd0,  4'd0, 28'h1234567},
    {28'hFEDCBA9, 4'd8,  4'd8, 28'hFEDCBA9},
    {28'hAAAAAAA, 4'd3,  4'd3, 28'hAAAAAAA},
    {28'h5555555, 4'd7,  4'd7, 28'h5555555},
    {28'h0000000, 4'd13, 4'd0, 28'h1234567},
    {28'hFFFFFFF, 4'd9,  4'd8, 28'hFEDCBA9},
    {28'h0000002, 4'd15, 4'd3, 28'hAAAAAAA},
    {28'h0000001, 4'd3,  4'd3, 28'h0000001}
  };

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, le = 1'b1, mosi = 1'b0;
  logic miso, locked;
  logic [9*28-1:0] cfg;
  int tests = 0, fails = 0;

  cfg_spi_slave i_cfg_spi_slave (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sclk(sclk), .le(le),
    .mosi(mosi), .miso(miso), .cfg_o(cfg), .nvm_locked_o(locked));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [3:0] a, input logic [27:0] d);
    return {d, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] w, input int nb, output logic [63:0] got);
    got = '0;
    @(negedge clk); le = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = w[i];
      repeat (4) @(negedge clk);
      got[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk); le = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] f);
    logic [63:0] g;
    xfer({32'h0, f}, 32, g);
  endtask

  task automatic rd(input logic [3:0] r, output logic [31:0] v);
    logic [63:0] g;
    xfer({32'h0, mk(4'hE, {24'h0, r})}, 32, g);
    xfer({32'h0, mk(4'd9, 28'h0)}, 32, g);
    v = g[31:0];
  endtask

  task automatic soft_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input int k);
    return {4'h0, cfg[k*28 +: 28]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] g;
    repeat (5) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 power-on state
    for (int k = 0; k < 9; k++) chk("R1 por word", word(k), 32'h0);
    chk("R1 por seal", {31'h0, locked}, 32'h0);
    chk("R4 idle miso", {31'h0, miso}, 32'h0);

    // R2 R3 R4 R8 table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][63:32]);
      rd(VEC[i][31:28], v);
      chk("R3 R4 R8 table miso", v, {VEC[i][27:0], VEC[i][31:28]});
      chk("R3 R8 table cfg", word(int'(VEC[i][31:28])), {4'h0, VEC[i][27:0]});
    end

    // R9 short and long frames
    xfer({32'h0, mk(4'd0, 28'h7777777)}, 31, g);
    chk("R9 short frame", word(0), 32'h1234567);
    xfer({31'h0, 1'b0, mk(4'd0, 28'h7777777)}, 33, g);
    chk("R9 long frame", word(0), 32'h1234567);
    rd(4'd0, v);
    chk("R9 R2 recovery", v, {28'h1234567, 4'd0});

    // R8 malformed reads arm nothing
    send(mk(4'hE, 28'h0000010));
    xfer({32'h0, mk(4'd9, 28'h0)}, 32, g);
    chk("R8 read high bits", g[31:0], 32'h0);
    rd(4'd9, v);
    chk("R8 read word 9", v, 32'h0);

    // R5 open copy, R10 word 8 not kept
    send(mk(4'hF, 28'h0000001));
    chk("R5 seal clear", {31'h0, locked}, 32'h0);
    send(mk(4'd0, 28'h0ABCDEF));
    send(mk(4'd8, 28'h1111111));
    chk("R3 write after copy", word(0), 32'h0ABCDEF);
    soft_reset();
    chk("R5 reload word0", word(0), 32'h1234567);
    chk("R5 reload word3", word(3), 32'h0000001);
    chk("R5 reload word7", word(7), 32'h5555555);
    chk("R10 word8 cleared", word(8), 32'h0);
    chk("R1 soft seal", {31'h0, locked}, 32'h0);

    // R8 near-miss copy payloads
    send(mk(4'd0, 28'h2222222));
    send(mk(4'hF, 28'h0000003));
    send(mk(4'hF, 28'h0000A02));
    soft_reset();
    chk("R8 no copy", word(0), 32'h1234567);

    // R6 sealing copy
    send(mk(4'd0, 28'h3333333));
    send(mk(4'hF, 28'h0000A03));
    chk("R6 seal set", {31'h0, locked}, 32'h1);
    soft_reset();
    chk("R6 reload", word(0), 32'h3333333);
    chk("R1 seal kept", {31'h0, locked}, 32'h1);

    // R7 sealed: writes work, copies ignored
    send(mk(4'd0, 28'h4444444));
    chk("R7 write sealed", word(0), 32'h4444444);
    send(mk(4'hF, 28'h0000001));
    send(mk(4'hF, 28'h0000A03));
    soft_reset();
    chk("R7 copy ignored", word(0), 32'h3333333);
    rd(4'd0, v);
    chk("R4 read sealed", v, {28'h3333333, 4'd0});

    // R1 power-on clears the seal
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk); por_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 por seal clear", {31'h0, locked}, 32'h0);
    chk("R1 por word0", word(0), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule